// File: doc/BRIEF.md
# Maskable Interrupt Cause Register Group

This block collects up to `WIDTH` hardware event sources into a single register group with one interrupt request. A one-cycle pulse on an event input latches the matching cause bit. Software can also raise cause bits on its own, which lets it trigger an interrupt without any hardware event. A mask register with one bit per source decides which latched causes drive the request line. A mask bit of 1 blocks its source.

Each cause bit has its own clear policy, held in a mode register. A bit in write-one-to-clear mode is cleared when software writes a 1 to it at the cause offset. The usual pattern is to write back the value just read. A bit in clear-on-read mode is cleared by the read that returns it. The mask never takes a direct write. Software sets mask bits through one offset and clears them through another, so sources can be enabled and disabled independently without a read-modify-write.

Access goes through a simple port with read and write strobes, a 3-bit word offset, write data and read data. Read data is combinational from the current state. Any clearing caused by a read takes effect at the clock edge that ends the read cycle.

Top module: `irq_cause_group`

## Requirements
- R1: After synchronous reset the cause register is 0, the mask is all ones, the mode register is 0 and `irq_o` is low.
- R2: A 1 on `evt_i[n]` in any cycle sets cause bit n from the next cycle on, and the bit stays set until it is cleared.
- R3: A write to offset 1 (software set) sets every cause bit whose write-data bit is 1. Reads of offset 1 return 0.
- R4: A write to offset 2 sets every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to offset 3 clears every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A write to offset 0 clears exactly those cause bits whose write-data bit is 1 and whose mode bit is 0. Cause bits whose mode bit is 1 are not affected by that write.
- R7: A read of offset 0 returns the cause register and clears those returned bits whose mode bit is 1 (offset 4 holds the mode, 1 = clear-on-read). Bits whose mode bit is 0 are unchanged by the read.
- R8: An event on a bit in the same cycle as a clear of that bit, by either write or read, leaves the bit set.
- R9: Offset 5 reads cause AND NOT mask. Offsets 2, 3 and 6 read the current mask. Offset 4 reads and writes the mode register.
- R10: `irq_o` is high exactly when at least one cause bit is set whose mask bit is 0.
- R11: Writes to offsets 5, 6 and 7 change no state. Reads of any offset other than 0 clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | WIDTH | Hardware event pulses, one per cause bit |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Word offset of the sub-register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid in the cycle of `rd_en` |
| irq_o | output | 1 | Interrupt request |

## Verification
A cause bit that is lost or stuck shows up in the next read of offsets 0 or 5. It also shows on `irq_o` in the cycle after the offending edge, once its mask bit has been cleared. A corrupted mask or mode register is visible at the next read of offsets 6 and 4. The bench reads state back only through offsets that have no side effects, or through a clear-on-read read whose result it has already predicted. A wrong clear policy is therefore caught within one access of the offending edge. The same-cycle event-versus-clear race is driven for both clear paths.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    localparam int DEF_WIDTH = 32;
    localparam int OFS_W     = 3;

    typedef enum logic [OFS_W-1:0] {
        SEL_CAUSE   = 3'd0,
        SEL_SWSET   = 3'd1,
        SEL_MSET    = 3'd2,
        SEL_MCLR    = 3'd3,
        SEL_MODE    = 3'd4,
        SEL_MCAUSE  = 3'd5,
        SEL_MVAL    = 3'd6,
        SEL_SPARE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cause_rd;
        logic cause_wr;
        logic swset_wr;
        logic mset_wr;
        logic mclr_wr;
        logic mode_wr;
    } strobe_t;

    function automatic strobe_t decode_access(logic rd, logic wr, reg_sel_e sel);
        strobe_t s;
        s          = '0;
        s.cause_rd = rd && (sel == SEL_CAUSE);
        s.cause_wr = wr && (sel == SEL_CAUSE);
        s.swset_wr = wr && (sel == SEL_SWSET);
        s.mset_wr  = wr && (sel == SEL_MSET);
        s.mclr_wr  = wr && (sel == SEL_MCLR);
        s.mode_wr  = wr && (sel == SEL_MODE);
        return s;
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic             mode_wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            mode_q <= '0;
        end else begin
            if (set_wr)
                mask_q <= mask_q | wdata;
            else if (clr_wr)
                mask_q <= mask_q & ~wdata;
            if (mode_wr)
                mode_q <= wdata;
        end
    end

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));

    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((mask_q & $past(wdata)) == '0));

    assert_reset_mask_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && mode_q == '0));

endmodule

// File: rtl/irq_cause_core.sv
module irq_cause_core
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt_i,
    input  strobe_t          stb,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] mode_q,
    output logic [WIDTH-1:0] cause_q
);

    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;

    assign set_vec = evt_i | (stb.swset_wr ? wdata : '0);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic w1c_hit;
            logic cor_hit;
            assign w1c_hit = stb.cause_wr && wdata[b] && !mode_q[b];
            assign cor_hit = stb.cause_rd && cause_q[b] && mode_q[b];
            assign clr_vec[b] = w1c_hit || cor_hit;

            always_ff @(posedge clk) begin
                if (rst)
                    cause_q[b] <= 1'b0;
                else if (set_vec[b])
                    cause_q[b] <= 1'b1;
                else if (clr_vec[b])
                    cause_q[b] <= 1'b0;
            end
        end
    endgenerate

    assert_evt_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    assert_cor_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (stb.cause_rd && evt_i == '0 && !stb.swset_wr)
            |=> ((cause_q & $past(cause_q & mode_q)) == '0));

    assert_w1c_keeps_cor_R6: assert property (@(posedge clk) disable iff (rst)
        (stb.cause_wr && !stb.cause_rd)
            |=> ((cause_q & $past(cause_q & mode_q)) == $past(cause_q & mode_q)));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  reg_sel_e         sel,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] cause_q,
    input  logic [WIDTH-1:0] mask_q,
    input  logic [WIDTH-1:0] mode_q,
    output logic [WIDTH-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CAUSE:                   rdata = cause_q;
                SEL_MSET, SEL_MCLR, SEL_MVAL: rdata = mask_q;
                SEL_MODE:                    rdata = mode_q;
                SEL_MCAUSE:                  rdata = cause_q & ~mask_q;
                default:                     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_cause_group.sv
module irq_cause_group
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             irq_o
);

    reg_sel_e         sel;
    strobe_t          stb;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] cause_q;

    assign sel = reg_sel_e'(addr);
    assign stb = decode_access(rd_en, wr_en, sel);

    irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_wr  (stb.mset_wr),
        .clr_wr  (stb.mclr_wr),
        .mode_wr (stb.mode_wr),
        .wdata   (wdata),
        .mask_q  (mask_q),
        .mode_q  (mode_q)
    );

    irq_cause_core #(.WIDTH(WIDTH)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .stb     (stb),
        .wdata   (wdata),
        .mode_q  (mode_q),
        .cause_q (cause_q)
    );

    irq_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .sel     (sel),
        .rd_en   (rd_en),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .mode_q  (mode_q),
        .rdata   (rdata)
    );

    assign irq_o = |(cause_q & ~mask_q);

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq_o);

    assert_ro_write_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= 3'd5) |=> ($stable(mask_q) && $stable(mode_q)));

endmodule

// File: tb/irq_cause_group_tb.sv
module irq_cause_group_tb_top;

    localparam int CLK_P = 10;
    localparam int W     = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] evt_i = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_cause_group #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d, logic [W-1:0] ev = '0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; evt_i = ev;
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0; wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [W-1:0] d, input logic [W-1:0] ev = '0);
        @(negedge clk);
        rd_en = 1'b1; addr = a; evt_i = ev;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; evt_i = '0;
    endtask

    task automatic pulse(logic [W-1:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(3'd6, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R1 mode", v, 32'h0);
        rd(3'd0, v); check("R1 cause", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_event_mask();
        logic [W-1:0] v;
        pulse(32'h5);
        rd(3'd0, v); check("R2 cause latched", v, 32'h5);
        check("R10 masked irq low", {31'b0, irq_o}, 32'h0);
        rd(3'd5, v); check("R9 masked cause", v, 32'h0);
        wr(3'd3, 32'h1);
        rd(3'd6, v); check("R5 mask clear", v, 32'hFFFF_FFFE);
        check("R10 irq high", {31'b0, irq_o}, 32'h1);
        rd(3'd5, v); check("R9 masked cause unmasked", v, 32'h1);
        rd(3'd2, v); check("R9 set offset reads mask", v, 32'hFFFF_FFFE);
        rd(3'd3, v); check("R9 clr offset reads mask", v, 32'hFFFF_FFFE);
        wr(3'd2, 32'h0);
        rd(3'd6, v); check("R4 zero write no change", v, 32'hFFFF_FFFE);
        wr(3'd2, 32'h1);
        rd(3'd6, v); check("R4 mask set", v, 32'hFFFF_FFFF);
        check("R10 irq low again", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [W-1:0] v;
        wr(3'd0, 32'h4);
        rd(3'd0, v); check("R6 w1c one bit", v, 32'h1);
        wr(3'd0, 32'h1);
        rd(3'd0, v); check("R6 w1c last bit", v, 32'h0);
    endtask

    task automatic t_swset();
        logic [W-1:0] v;
        wr(3'd1, 32'h8000_0000);
        rd(3'd0, v); check("R3 sw set", v, 32'h8000_0000);
        rd(3'd1, v); check("R3 sw offset reads zero", v, 32'h0);
        wr(3'd3, 32'h8000_0000);
        check("R10 sw irq", {31'b0, irq_o}, 32'h1);
        wr(3'd0, 32'h8000_0000);
        check("R10 cleared irq", {31'b0, irq_o}, 32'h0);
        wr(3'd2, 32'h8000_0000);
    endtask

    task automatic t_cor();
        logic [W-1:0] v;
        wr(3'd4, 32'hF0);
        rd(3'd4, v); check("R9 mode readback", v, 32'hF0);
        pulse(32'h11);
        rd(3'd0, v); check("R7 first read", v, 32'h11);
        rd(3'd0, v); check("R7 cor bit cleared", v, 32'h01);
        pulse(32'h10);
        wr(3'd0, 32'h10);
        rd(3'd0, v); check("R6 write ignores cor bit", v, 32'h11);
        rd(3'd0, v); check("R7 cleared after read", v, 32'h01);
        wr(3'd0, 32'h1);
        rd(3'd0, v); check("R6 w1c mixed", v, 32'h0);
    endtask

    task automatic t_race();
        logic [W-1:0] v;
        pulse(32'h4);
        wr(3'd0, 32'h4, 32'h4);
        rd(3'd0, v); check("R8 w1c race", v, 32'h4);
        wr(3'd0, 32'h4);
        pulse(32'h20);
        rd(3'd0, v, 32'h20); check("R8 cor race read", v, 32'h20);
        rd(3'd0, v); check("R8 cor race kept", v, 32'h20);
        rd(3'd0, v); check("R7 cor race cleared", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [W-1:0] v;
        wr(3'd5, 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h0);
        rd(3'd6, v); check("R11 mask untouched", v, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R11 mode untouched", v, 32'hF0);
        pulse(32'h40);
        rd(3'd5, v);
        rd(3'd6, v);
        rd(3'd4, v);
        rd(3'd1, v);
        rd(3'd0, v); check("R11 other reads no clear", v, 32'h40);
        rd(3'd0, v); check("R7 cleared", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event_mask();
        t_w1c();
        t_swset();
        t_cor();
        t_race();
        t_readonly();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule